// File: doc/BRIEF.md
# Down-Spread Modulation Profile Generator

This block generates the digital frequency-offset word that a clock synthesizer applies to its feedback divider or fractional accumulator, so that the synthesized clock is swept periodically between its nominal frequency and a lower limit. The sweep is a symmetric triangle, and it only ever reduces the frequency. Two depths are available, and a single select bit chooses between them. The sweep period is set by a step divider on the reference clock, which keeps the modulation rate far below the output clock rate.

The offset is a signed two's-complement code in units of 1/65536 of nominal frequency. A strobe marks every profile step, so the consumer can load the new word on that cycle. Two inputs force the offset to zero and so turn the modulation off: an active-low spread enable that is driven high, or a test-mode input that is driven high. When modulation is allowed again, the profile restarts at zero offset at the beginning of a period. A change of depth is applied only at a period boundary, so the profile never jumps from one depth to the other in the middle of a sweep.

Top module: `ssmod_profile_gen`

## Requirements
- R1: `freq_ofs` (16-bit two's complement, units of 1/65536 of nominal) is never greater than 0 and never below -2458.
- R2: With `depth_sel` = 0 the lowest offset reached in a period is exactly -819, which is 1.25 % below nominal.
- R3: With `depth_sel` = 1 the lowest offset reached in a period is exactly -2458, which is 3.75 % below nominal.
- R4: While `spread_n` is 1, from the first clock edge that samples it onward, `freq_ofs` is 0 and `step_stb` is 0.
- R5: While `test_mode` is 1, from the first clock edge that samples it onward, `freq_ofs` is 0 and `step_stb` is 0, whatever `spread_n` is.
- R6: While modulation runs, `step_stb` pulses for one cycle every `step_div`+1 reference clocks, and `freq_ofs` changes only in a cycle where `step_stb` is 1.
- R7: One period has 2*HALF_STEPS steps, which is 32 by default. At step k (counted 1 to 2*HALF_STEPS, modulo the period), `freq_ofs` = -floor(D*t/HALF_STEPS). Here t = k for k <= HALF_STEPS, t = 2*HALF_STEPS-k otherwise, and D is 819 or 2458.
- R8: After modulation is re-allowed, the clock edge that samples the change is a start cycle. The first strobe follows `step_div`+2 edges after it, counting that edge, and carries the step-1 value of a new period.
- R9: `depth_sel` is sampled only at the start cycle and at the step that closes a period. A change in mid-period leaves the remaining steps of that period on the old depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spread_n | input | 1 | Active-low spread enable; 1 forces zero offset |
| depth_sel | input | 1 | Depth select: 0 gives 1.25 %, 1 gives 3.75 % |
| test_mode | input | 1 | 1 forces zero offset and stops the profile |
| step_div | input | 16 | Reference clocks per profile step, minus one |
| freq_ofs | output | 16 | Signed frequency-offset code |
| step_stb | output | 1 | One-cycle pulse with each new offset value |

## Verification
The profile is followed step by step against a closed-form triangle. This is done at step dividers 0, 1, 2 and 3 and at both depths. The spacing between strobes then separates a prescaler fault from a shape fault, and a complete period at each depth confirms the exact floor value. Modulation is switched off in mid-sweep, once by the enable and once by test mode. It is then switched back on, which shows whether the profile restarts with its longer first step or resumes where it stopped. The depth select is flipped in mid-period, and the remaining steps of that period must keep the old slope while the next period takes the new one.

// File: rtl/ssmod_pkg.sv
package ssmod_pkg;
  localparam int OFS_W = 16;
  localparam int DIV_W = 16;

  typedef logic signed [OFS_W-1:0] ofs_t;
  typedef logic [DIV_W-1:0]        div_t;

  // Distance from the zero-offset end of the triangle for a position in the period.
  function automatic int unsigned tri_index(input int unsigned pos, input int unsigned half);
    return (pos <= half) ? pos : (2 * half - pos);
  endfunction

  // Offset code for a triangle index: magnitude truncated toward zero, sign negative.
  function automatic ofs_t scale_offset(input int unsigned depth, input int unsigned idx,
                                        input int unsigned half);
    int m;
    m = int'((depth * idx) / half);
    return ofs_t'(-m);
  endfunction
endpackage

// File: rtl/ssmod_step_timer.sv
module ssmod_step_timer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ssmod_phase_ctr.sv
module ssmod_phase_ctr #(
  parameter int HALF_STEPS = 16,
  localparam int PERIOD    = 2 * HALF_STEPS,
  localparam int POS_W     = $clog2(PERIOD)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  output logic [POS_W-1:0] pos,
  output logic [POS_W-1:0] next_pos,
  output logic             wrap
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(PERIOD - 1);

  assign next_pos = (pos == LAST_POS) ? '0 : pos + 1'b1;
  assign wrap     = tick && (pos == LAST_POS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pos <= '0;
    else if (!run)  pos <= '0;
    else if (tick)  pos <= next_pos;
  end
endmodule

// File: rtl/ssmod_profile_gen.sv
module ssmod_profile_gen #(
  parameter int HALF_STEPS = 16,
  parameter int DEPTH_LO   = 819,
  parameter int DEPTH_HI   = 2458,
  localparam int POS_W     = $clog2(2 * HALF_STEPS)
) (
  input  logic                           clk_ref,
  input  logic                           rst_n,
  input  logic                           spread_n,
  input  logic                           depth_sel,
  input  logic                           test_mode,
  input  logic [ssmod_pkg::DIV_W-1:0]    step_div,
  output logic signed [ssmod_pkg::OFS_W-1:0] freq_ofs,
  output logic                           step_stb
);
  import ssmod_pkg::*;

  // Named internal events, observed by the bound checker.
  logic             active;
  logic             run_q;
  logic             depth_q;
  logic             step_tick;
  logic             period_wrap;
  logic             counting;
  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] next_pos;
  int unsigned      depth_mag;
  ofs_t             next_ofs;

  assign active    = !spread_n && !test_mode;
  assign counting  = active && run_q;
  assign depth_mag = depth_q ? int'(DEPTH_HI) : int'(DEPTH_LO);
  assign next_ofs  = scale_offset(depth_mag, tri_index(32'(next_pos), HALF_STEPS), HALF_STEPS);

  ssmod_step_timer #(.DIV_W(DIV_W)) u_timer (
    .clk  (clk_ref),
    .rst_n(rst_n),
    .run  (counting),
    .div  (step_div),
    .tick (step_tick)
  );

  ssmod_phase_ctr #(.HALF_STEPS(HALF_STEPS)) u_phase (
    .clk     (clk_ref),
    .rst_n   (rst_n),
    .run     (counting),
    .tick    (step_tick),
    .pos     (pos),
    .next_pos(next_pos),
    .wrap    (period_wrap)
  );

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      depth_q  <= 1'b0;
      freq_ofs <= '0;
      step_stb <= 1'b0;
    end else if (!active) begin
      run_q    <= 1'b0;
      freq_ofs <= '0;
      step_stb <= 1'b0;
    end else if (!run_q) begin
      // Start cycle: a fresh period begins with the current depth.
      run_q    <= 1'b1;
      depth_q  <= depth_sel;
      step_stb <= 1'b0;
    end else begin
      step_stb <= step_tick;
      if (step_tick)   freq_ofs <= next_ofs;
      if (period_wrap) depth_q  <= depth_sel;
    end
  end
endmodule

// File: rtl/ssmod_profile_chk.sv
module ssmod_profile_chk #(
  parameter int HALF_STEPS = 16,
  parameter int DEPTH_LO   = 819,
  parameter int DEPTH_HI   = 2458
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic                                spread_n,
  input logic                                test_mode,
  input logic signed [ssmod_pkg::OFS_W-1:0]  freq_ofs,
  input logic                                step_stb,
  input logic                                active,
  input logic                                run_q,
  input logic                                depth_q,
  input logic                                step_tick,
  input logic                                period_wrap
);
  localparam int SLOPE = DEPTH_HI / HALF_STEPS + 1;

  a_r1_not_positive: assert property (@(posedge clk) disable iff (!rst_n)
    int'(freq_ofs) <= 0);

  a_r1_floor: assert property (@(posedge clk) disable iff (!rst_n)
    int'(freq_ofs) >= -DEPTH_HI);

  a_r2_shallow_floor: assert property (@(posedge clk) disable iff (!rst_n)
    !depth_q |-> int'(freq_ofs) >= -DEPTH_LO);

  a_r4_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
    spread_n |=> (freq_ofs == '0) && !step_stb);

  a_r5_test_zero: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode |=> (freq_ofs == '0) && !step_stb);

  a_r6_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(active) && !step_stb) |-> $stable(freq_ofs));

  a_r6_strobe_source: assert property (@(posedge clk) disable iff (!rst_n)
    step_stb |-> $past(step_tick));

  a_r7_slope: assert property (@(posedge clk) disable iff (!rst_n)
    step_stb |-> ((int'(freq_ofs) - int'($past(freq_ofs)) <= SLOPE) &&
                  (int'(freq_ofs) - int'($past(freq_ofs)) >= -SLOPE)));

  a_r8_start_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !run_q) |=> !step_stb && (freq_ofs == '0));

  a_r9_depth_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && active && !period_wrap) |=> $stable(depth_q));
endmodule

bind ssmod_profile_gen ssmod_profile_chk #(
  .HALF_STEPS(HALF_STEPS), .DEPTH_LO(DEPTH_LO), .DEPTH_HI(DEPTH_HI)
) u_chk (
  .clk        (clk_ref),
  .rst_n      (rst_n),
  .spread_n   (spread_n),
  .test_mode  (test_mode),
  .freq_ofs   (freq_ofs),
  .step_stb   (step_stb),
  .active     (active),
  .run_q      (run_q),
  .depth_q    (depth_q),
  .step_tick  (step_tick),
  .period_wrap(period_wrap)
);

// File: tb/tb_ssmod_profile_gen.sv
`timescale 1ns/1ps
module tb_ssmod_profile_gen;
  localparam int H      = 16;
  localparam int PER    = 2 * H;
  localparam int D_LO   = 819;
  localparam int D_HI   = 2458;

  logic        clk_ref = 1'b0;
  logic        rst_n;
  logic        spread_n;
  logic        depth_sel;
  logic        test_mode;
  logic [15:0] step_div;
  logic signed [15:0] freq_ofs;
  logic        step_stb;

  int checks = 0;
  int fails  = 0;
  int cur_k  = 0;
  int min_seen;
  bit done   = 1'b0;

  always #2.5 clk_ref = ~clk_ref;

  ssmod_profile_gen dut (
    .clk_ref  (clk_ref),
    .rst_n    (rst_n),
    .spread_n (spread_n),
    .depth_sel(depth_sel),
    .test_mode(test_mode),
    .step_div (step_div),
    .freq_ofs (freq_ofs),
    .step_stb (step_stb)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Expected offset at step k of a period, restated from the triangle rule.
  function automatic int model_ofs(input int dep, input int k);
    int t;
    int mag;
    t = (k <= H) ? k : PER - k;
    mag = 0;
    for (int acc = dep * t; acc >= H; acc -= H) mag++;
    return -mag;
  endfunction

  // Follow n profile steps; first=1 means the step after a start cycle.
  task automatic run_steps(input bit first, input int n, input int dep, input string req);
    int gap;
    int prev;
    for (int s = 0; s < n; s++) begin
      gap  = (first && s == 0) ? int'(step_div) + 2 : int'(step_div) + 1;
      prev = int'(freq_ofs);
      for (int i = 1; i < gap; i++) begin
        @(negedge clk_ref);
        if (step_stb || int'(freq_ofs) != prev)
          check(1'b0, "R6 idle between steps", int'(freq_ofs), prev);
      end
      @(negedge clk_ref);
      check(step_stb, first && s == 0 ? "R8 first strobe spacing" : "R6 strobe spacing",
            int'(step_stb), 1);
      cur_k = (cur_k + 1) % PER;
      check(int'(freq_ofs) == model_ofs(dep, cur_k), req, int'(freq_ofs), model_ofs(dep, cur_k));
      check(int'(freq_ofs) <= 0 && int'(freq_ofs) >= -D_HI, "R1 range", int'(freq_ofs), 0);
      if (int'(freq_ofs) < min_seen) min_seen = int'(freq_ofs);
    end
  endtask

  task automatic hold_zero(input int cycles, input string req);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk_ref);
      check(freq_ofs == 0 && !step_stb, req, int'(freq_ofs), 0);
    end
  endtask

  initial begin
    rst_n = 1'b0; spread_n = 1'b1; depth_sel = 1'b0; test_mode = 1'b0; step_div = 16'd0;
    repeat (3) @(negedge clk_ref);
    check(freq_ofs == 0 && !step_stb, "R4 reset state", int'(freq_ofs), 0);
    rst_n = 1'b1;
    hold_zero(4, "R4 enable high");

    // Depth 0, divider 0: two full periods.
    spread_n = 1'b0; cur_k = 0; min_seen = 0;
    run_steps(1'b1, PER, D_LO, "R7 shape d0 div0");
    check(min_seen == -D_LO, "R2 floor depth0", min_seen, -D_LO);
    run_steps(1'b0, PER, D_LO, "R7 shape d0 div0 p2");

    // Turn off in mid-sweep by the enable.
    run_steps(1'b0, 7, D_LO, "R7 shape d0 partial");
    spread_n = 1'b1;
    @(negedge clk_ref);
    check(freq_ofs == 0 && !step_stb, "R4 forced zero", int'(freq_ofs), 0);
    hold_zero(10, "R4 held zero");

    // Depth 1, divider 2: restart and a full period.
    step_div = 16'd2; depth_sel = 1'b1; spread_n = 1'b0; cur_k = 0; min_seen = 0;
    run_steps(1'b1, PER, D_HI, "R8 restart shape d1 div2");
    check(min_seen == -D_HI, "R3 floor depth1", min_seen, -D_HI);

    // Test mode in mid-sweep overrides the enable.
    run_steps(1'b0, 5, D_HI, "R7 shape d1 partial");
    test_mode = 1'b1;
    @(negedge clk_ref);
    check(freq_ofs == 0 && !step_stb, "R5 forced zero", int'(freq_ofs), 0);
    hold_zero(12, "R5 held zero");
    test_mode = 1'b0; step_div = 16'd1; cur_k = 0;
    run_steps(1'b1, 7, D_HI, "R8 restart after test d1 div1");

    // Depth change in mid-period waits for the boundary.
    depth_sel = 1'b0;
    run_steps(1'b0, PER - 7, D_HI, "R9 old depth kept");
    min_seen = 0;
    run_steps(1'b0, PER, D_LO, "R9 new depth applied");
    check(min_seen == -D_LO, "R9 new floor", min_seen, -D_LO);

    // Larger divider, depth 0 after a fresh start.
    spread_n = 1'b1; @(negedge clk_ref); @(negedge clk_ref);
    step_div = 16'd3; spread_n = 1'b0; cur_k = 0;
    run_steps(1'b1, PER, D_LO, "R6 R7 shape d0 div3");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_ref);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule